// File: doc/BRIEF.md
# Saturating 64-by-32 Integer Divide Unit

This unit divides a 64-bit dividend by a 32-bit divisor over many cycles. It is meant to sit beside the integer datapath of a 64-bit processor. The dividend is built from two pieces: a 32-bit extension register supplies the upper half, and the low 32 bits of the first operand supply the lower half. The divisor is the low 32 bits of the second operand. A mode input chooses two's-complement or unsigned division.

The quotient is rounded toward zero. When it does not fit in 32 bits, the unit replaces it with the nearest representable limit and raises an overflow flag. In-range results come out as a 64-bit value: sign-extended in signed mode and zero-extended in unsigned mode. The carry flag produced for these operations is always clear.

The unit uses a restoring shift-subtract loop that produces one quotient bit per cycle. A request is made with a single-cycle `start`. The result is valid during a one-cycle `done` pulse. A zero divisor ends the request with a fault pulse instead of a result.

Top module: `satDivTop`

## Requirements
- R1: Dividend = {yIn[31:0], srcA[31:0]} and divisor = srcB[31:0]. srcA[63:32] and srcB[63:32] have no effect on the result, on the flags or on zero detection.
- R2: If the divisor is zero when start is accepted, divFault is high for exactly the next cycle. busy stays low, done does not assert, and result and ovfFlag keep their previous values.
- R3: In signed mode (signedMode=1), an in-range quotient is truncated toward zero and sign-extended to 64 bits, with ovfFlag=0. A quotient of exactly -2^31 is in range.
- R4: In signed mode, a quotient above 2^31-1 gives result 64'h000000007FFFFFFF and ovfFlag=1.
- R5: In signed mode, a quotient below -2^31 gives result 64'hFFFFFFFF80000000 and ovfFlag=1.
- R6: In unsigned mode (signedMode=0), a quotient up to 2^32-1 is zero-extended with ovfFlag=0. A larger quotient gives 64'h00000000FFFFFFFF and ovfFlag=1.
- R7: carryFlag is 0 with every result.
- R8: done is a one-cycle pulse. It is first seen 66 cycles after the cycle in which start was accepted (2×32+2). busy is high from the cycle after acceptance through the done cycle.
- R9: start is ignored while busy is high, including start with a zero divisor. The running operation completes with its own operands.
- R10: After reset, busy, done, divFault, ovfFlag and result are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a divide (accepted only when idle) |
| signedMode | input | 1 | 1 = two's-complement, 0 = unsigned |
| yIn | input | 32 | Upper half of the dividend |
| srcA | input | 64 | First operand; low half is the dividend's lower half |
| srcB | input | 64 | Second operand; low half is the divisor |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle result-valid pulse |
| divFault | output | 1 | One-cycle division-by-zero fault |
| result | output | 64 | Saturated, extended quotient |
| ovfFlag | output | 1 | Quotient was clamped |
| carryFlag | output | 1 | Carry condition flag (always 0) |

## Verification
The bench covers the edges of the saturation window and what a wrong design would do at each:
- **Quotients of exactly 2^31-1 and -2^31.** A design with an off-by-one limit would clamp these or flag them.
- **A quotient of +2^31.** A design that compares without the sign would let it through as a negative number.
- **A dividend of -2^63.** Its magnitude only fits in an unsigned 64-bit value, so a design that takes magnitudes with too few bits would produce a wrong sign or a wrong quotient.
- **Mixed-sign truncation and stray upper operand bits.** These show whether the sign fix-up, the rounding toward zero and the operand slicing are correct.
- **Zero divisor and start while busy.** A zero divisor must not disturb the held result, and a start that arrives mid-run must not restart the loop or corrupt it.

// File: rtl/satDivPkg.sv
package satDivPkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_FIX,
    ST_DONE
  } divState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;    // capture operand magnitudes
    logic step;    // one shift-subtract iteration
    logic finish;  // sign fix-up, saturation, result write
  } divStrobe_t;
endpackage

// File: rtl/divCtrl.sv
module divCtrl
  import satDivPkg::*;
#(
  parameter int ITER = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       divisorZero,
  output divStrobe_t strobe,
  output logic       busy,
  output logic       done,
  output logic       divFault
);
  localparam int CW = (ITER > 1) ? $clog2(ITER) : 1;
  localparam logic [CW-1:0] LAST = CW'(ITER - 1);

  divState_e state;
  logic [CW-1:0] iterCnt;
  logic faultR;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      iterCnt <= '0;
      faultR  <= 1'b0;
    end else begin
      faultR <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            if (divisorZero) begin
              faultR <= 1'b1;
            end else begin
              state   <= ST_RUN;
              iterCnt <= '0;
            end
          end
        end
        ST_RUN: begin
          iterCnt <= iterCnt + CW'(1);
          if (iterCnt == LAST) state <= ST_FIX;
        end
        ST_FIX:  state <= ST_DONE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.load   = (state == ST_IDLE) && start && !divisorZero;
    strobe.step   = (state == ST_RUN);
    strobe.finish = (state == ST_FIX);
  end

  assign busy     = (state != ST_IDLE);
  assign done     = (state == ST_DONE);
  assign divFault = faultR;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R8
  AST_FAULT_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    divFault |-> (!busy && !done)); // R2
  AST_LOOP_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && iterCnt != LAST) |=>
      (state == ST_RUN && iterCnt == $past(iterCnt) + CW'(1))); // R9
endmodule

// File: rtl/divDatapath.sv
module divDatapath
  import satDivPkg::*;
#(
  parameter int HALF_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  divStrobe_t          strobe,
  input  logic                doneIn,
  input  logic                signedMode,
  input  logic [HALF_W-1:0]   yIn,
  input  logic [2*HALF_W-1:0] srcA,
  input  logic [2*HALF_W-1:0] srcB,
  output logic                divisorZero,
  output logic [2*HALF_W-1:0] result,
  output logic                ovfFlag,
  output logic                carryFlag
);
  localparam int FULL_W = 2 * HALF_W;
  localparam logic [FULL_W-1:0] POS_LIM = {{(HALF_W+1){1'b0}}, {(HALF_W-1){1'b1}}};
  localparam logic [FULL_W-1:0] NEG_LIM = {{(HALF_W+1){1'b1}}, {(HALF_W-1){1'b0}}};
  localparam logic [FULL_W-1:0] NEG_MAG = {{HALF_W{1'b0}}, 1'b1, {(HALF_W-1){1'b0}}};
  localparam logic [FULL_W-1:0] U_LIM   = {{HALF_W{1'b0}}, {HALF_W{1'b1}}};

  // Operand forming and magnitudes
  logic [FULL_W-1:0] dividend, dvdMag;
  logic [HALF_W-1:0] divisor, dvsMag;
  logic dvdNeg, dvsNeg;

  always_comb begin
    dividend = {yIn, srcA[HALF_W-1:0]};
    divisor  = srcB[HALF_W-1:0];
    dvdNeg   = signedMode && dividend[FULL_W-1];
    dvsNeg   = signedMode && divisor[HALF_W-1];
    dvdMag   = dvdNeg ? (~dividend + FULL_W'(1)) : dividend;
    dvsMag   = dvsNeg ? (~divisor + HALF_W'(1)) : divisor;
  end
  assign divisorZero = (divisor == '0);

  // Iteration state
  logic [FULL_W-1:0] quoR;
  logic [HALF_W-1:0] remR, dvsR;
  logic negQR, sgnR;
  logic [FULL_W-1:0] resultR;
  logic ovfR;

  logic [HALF_W:0]   trial;
  logic [HALF_W+1:0] diff;
  logic              fits;

  always_comb begin
    trial = {remR, quoR[FULL_W-1]};
    diff  = {1'b0, trial} - {2'b00, dvsR};
    fits  = !diff[HALF_W+1];
  end

  // Sign fix-up and saturation
  logic [FULL_W-1:0] fixVal;
  logic              fixOvf;

  always_comb begin
    fixVal = quoR;
    fixOvf = 1'b0;
    if (!sgnR) begin
      if (quoR > U_LIM) begin
        fixVal = U_LIM;
        fixOvf = 1'b1;
      end
    end else if (!negQR) begin
      if (quoR > POS_LIM) begin
        fixVal = POS_LIM;
        fixOvf = 1'b1;
      end
    end else begin
      if (quoR > NEG_MAG) begin
        fixVal = NEG_LIM;
        fixOvf = 1'b1;
      end else begin
        fixVal = ~quoR + FULL_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      quoR    <= '0;
      remR    <= '0;
      dvsR    <= '0;
      negQR   <= 1'b0;
      sgnR    <= 1'b0;
      resultR <= '0;
      ovfR    <= 1'b0;
    end else begin
      if (strobe.load) begin
        quoR  <= dvdMag;
        remR  <= '0;
        dvsR  <= dvsMag;
        negQR <= dvdNeg ^ dvsNeg;
        sgnR  <= signedMode;
      end else if (strobe.step) begin
        quoR <= {quoR[FULL_W-2:0], fits};
        remR <= fits ? diff[HALF_W-1:0] : trial[HALF_W-1:0];
      end
      if (strobe.finish) begin
        resultR <= fixVal;
        ovfR    <= fixOvf;
      end
    end
  end

  assign result    = resultR;
  assign ovfFlag   = ovfR;
  assign carryFlag = 1'b0;

  AST_SIGNED_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (doneIn && sgnR && !ovfR) |->
      (resultR[FULL_W-1:HALF_W-1] == '0 || resultR[FULL_W-1:HALF_W-1] == '1)); // R3
  AST_SIGNED_CLAMP: assert property (@(posedge clk) disable iff (!rstN)
    (doneIn && sgnR && ovfR) |-> (resultR == POS_LIM || resultR == NEG_LIM)); // R4
  AST_UNSIGNED_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (doneIn && !sgnR) |-> (resultR[FULL_W-1:HALF_W] == '0)); // R6
endmodule

// File: rtl/satDivTop.sv
module satDivTop
  import satDivPkg::*;
#(
  parameter int HALF_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic                signedMode,
  input  logic [HALF_W-1:0]   yIn,
  input  logic [2*HALF_W-1:0] srcA,
  input  logic [2*HALF_W-1:0] srcB,
  output logic                busy,
  output logic                done,
  output logic                divFault,
  output logic [2*HALF_W-1:0] result,
  output logic                ovfFlag,
  output logic                carryFlag
);
  localparam int ITER = 2 * HALF_W;

  divStrobe_t strobe;
  logic divisorZero;

  divCtrl #(.ITER(ITER)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .divisorZero(divisorZero),
    .strobe(strobe), .busy(busy), .done(done), .divFault(divFault)
  );

  divDatapath #(.HALF_W(HALF_W)) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .doneIn(done),
    .signedMode(signedMode), .yIn(yIn), .srcA(srcA), .srcB(srcB),
    .divisorZero(divisorZero), .result(result), .ovfFlag(ovfFlag),
    .carryFlag(carryFlag)
  );

  AST_RESULT_NOT_TOUCHED_BY_FAULT: assert property (@(posedge clk) disable iff (!rstN)
    divFault |-> ($stable(result) && $stable(ovfFlag))); // R2
endmodule

// File: tb/sim_satDivTop.sv
module sim_satDivTop;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic signedMode = 1'b0;
  logic [31:0] yIn = '0;
  logic [63:0] srcA = '0, srcB = '0;
  logic busy, done, divFault, ovfFlag, carryFlag;
  logic [63:0] result;

  always #2.5 clk = ~clk;

  satDivTop u0 (
    .clk(clk), .rstN(rstN), .start(start), .signedMode(signedMode),
    .yIn(yIn), .srcA(srcA), .srcB(srcB), .busy(busy), .done(done),
    .divFault(divFault), .result(result), .ovfFlag(ovfFlag),
    .carryFlag(carryFlag)
  );

  typedef struct packed {
    logic        sgn;
    logic [31:0] y;
    logic [63:0] a;
    logic [63:0] b;
    logic [63:0] res;
    logic        ovf;
    logic [15:0] tag;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 32'h0,        64'd100,                 64'd7,                   64'd14,                  1'b0, "R6"},
    '{1'b1, 32'hFFFFFFFF, 64'h00000000FFFFFF9C,    64'd7,                   64'hFFFFFFFFFFFFFFF2,    1'b0, "R3"},
    '{1'b1, 32'h1,        64'h0,                   64'd1,                   64'h000000007FFFFFFF,    1'b1, "R4"},
    '{1'b1, 32'h1,        64'h0,                   64'h00000000FFFFFFFF,    64'hFFFFFFFF80000000,    1'b1, "R5"},
    '{1'b1, 32'h0,        64'h0000000080000000,    64'h00000000FFFFFFFF,    64'hFFFFFFFF80000000,    1'b0, "R5"},
    '{1'b1, 32'h0,        64'h000000007FFFFFFF,    64'd1,                   64'h000000007FFFFFFF,    1'b0, "R4"},
    '{1'b1, 32'h0,        64'h0000000080000000,    64'd1,                   64'h000000007FFFFFFF,    1'b1, "R4"},
    '{1'b0, 32'h1,        64'h0,                   64'd1,                   64'h00000000FFFFFFFF,    1'b1, "R6"},
    '{1'b0, 32'h0,        64'h00000000FFFFFFFF,    64'd1,                   64'h00000000FFFFFFFF,    1'b0, "R6"},
    '{1'b0, 32'h0,        64'hDEADBEEF00000064,    64'h1234567800000007,    64'd14,                  1'b0, "R1"},
    '{1'b1, 32'hFFFFFFFF, 64'h00000000FFFFFFF9,    64'd2,                   64'hFFFFFFFFFFFFFFFD,    1'b0, "R3"},
    '{1'b1, 32'h0,        64'd100,                 64'h00000000FFFFFFF9,    64'hFFFFFFFFFFFFFFF2,    1'b0, "R3"},
    '{1'b0, 32'h0,        64'h00000000FFFFFFFF,    64'h00000000FFFFFFFF,    64'd1,                   1'b0, "R6"},
    '{1'b1, 32'h80000000, 64'h0,                   64'h00000000FFFFFFFF,    64'h000000007FFFFFFF,    1'b1, "R4"}
  };

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Issue one request; returns number of cycles until done is seen
  task automatic runOp(input logic sgn, input logic [31:0] y, input logic [63:0] a,
                       input logic [63:0] b, output int lat);
    @(negedge clk);
    signedMode = sgn; yIn = y; srcA = a; srcB = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 1000) begin
      @(negedge clk);
      lat++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int lat;
    logic [63:0] held;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 busy", {63'd0, busy}, 64'd0);
    chk("R10 done", {63'd0, done}, 64'd0);
    chk("R10 fault", {63'd0, divFault}, 64'd0);
    chk("R10 result", result, 64'd0);
    chk("R10 ovf", {63'd0, ovfFlag}, 64'd0);
    rstN = 1'b1;

    // Vector table
    for (int i = 0; i < NV; i++) begin
      runOp(VECS[i].sgn, VECS[i].y, VECS[i].a, VECS[i].b, lat);
      chk($sformatf("%s vec%0d result", VECS[i].tag, i), result, VECS[i].res);
      chk($sformatf("%s vec%0d ovf", VECS[i].tag, i), {63'd0, ovfFlag}, {63'd0, VECS[i].ovf});
      chk($sformatf("R7 vec%0d carry", i), {63'd0, carryFlag}, 64'd0);
      chk($sformatf("R8 vec%0d latency", i), 64'(lat), 64'd66);
    end

    // R8 busy window and single-cycle done
    @(negedge clk);
    chk("R8 done one cycle", {63'd0, done}, 64'd0);
    @(negedge clk);
    signedMode = 1'b0; yIn = 0; srcA = 64'd50; srcB = 64'd5; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R8 busy after start", {63'd0, busy}, 64'd1);
    // R9 start with other operands (and a zero divisor) while busy
    repeat (10) @(negedge clk);
    srcA = 64'd999; srcB = 64'd0; start = 1'b1;
    @(negedge clk);
    chk("R9 no fault while busy", {63'd0, divFault}, 64'd0);
    srcB = 64'd3; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 13;
    while (!done && lat < 1000) begin
      @(negedge clk);
      lat++;
    end
    chk("R9 latency unchanged", 64'(lat), 64'd66);
    chk("R9 result of first op", result, 64'd10);
    chk("R8 busy during done", {63'd0, busy}, 64'd1);

    // R2 zero divisor, with upper bits of srcB set (R1)
    held = result;
    @(negedge clk);
    @(negedge clk);
    signedMode = 1'b1; yIn = 32'h1; srcA = 64'd7; srcB = 64'hFFFF000000000000; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R2 fault pulse", {63'd0, divFault}, 64'd1);
    chk("R2 busy low", {63'd0, busy}, 64'd0);
    chk("R1 zero detect uses low half", {63'd0, divFault}, 64'd1);
    @(negedge clk);
    chk("R2 fault single cycle", {63'd0, divFault}, 64'd0);
    chk("R2 no done", {63'd0, done}, 64'd0);
    chk("R2 busy stays low", {63'd0, busy}, 64'd0);
    repeat (5) @(negedge clk);
    chk("R2 result held", result, held);
    chk("R2 ovf held", {63'd0, ovfFlag}, 64'd0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule